// File: doc/BRIEF.md
# Receive Framer with CRC Check

This block sits behind a subcarrier decoder in a reader's receive path. After the transmitter reports the end of a command, it ignores the incoming bit strobe for a programmable guard interval, then waits for the tag's reply. It packs the decoded bits into bytes, most significant bit first, and pushes them into a 24-byte first-word-fall-through FIFO that the host drains. When the frame ends, it checks the trailing 16-bit CRC and compares the received length against an expected bit count. It then reports the outcome through a sticky interrupt status register.

The expected length comes from a register that the host writes. In the variable-length mode, the block raises an early interrupt once 16 bits have arrived. The host can then read the first two bytes and write the real length while the frame is still running. A missing reply, a preamble fault reported by the decoder, a stream that ends short, a CRC mismatch and a FIFO overflow each have their own cause bit.

The controller has five states:
- `ST_IDLE`: waiting for a transmit-end pulse.
- `ST_GUARD`: bits are ignored while the guard counter runs down.
- `ST_LISTEN`: waiting for the first bit, with a no-response timeout.
- `ST_RECV`: collecting bits.
- `ST_FINISH`: one cycle that flushes a partial byte and judges the frame.

The transitions are:
- Any state goes to GUARD on a transmit-end pulse, or straight to LISTEN when the guard value is zero.
- GUARD goes to LISTEN when its counter expires.
- LISTEN goes to RECV on the first bit, to FINISH if that first bit already ends the frame, and to IDLE on a timeout or a preamble fault.
- RECV goes to FINISH on a frame end, and to IDLE on a preamble fault or an overflow.
- FINISH goes to IDLE.

Top module: `rx_framer`

## Requirements
- R1: After `tx_done`, bits are ignored for `guard_cycles*GUARD_UNIT` clock cycles. The first bit strobed after that interval is accepted.
- R2: Accepted bits are packed MSB first into bytes and written to a FIFO of DEPTH bytes, which the host pops with `rd_en`. `rd_data` shows the oldest byte, and `fifo_count` gives the occupancy. When a frame ends with 1 to 7 leftover bits, those bits are pushed in the upper positions of one more byte, with zeros below.
- R3: A byte that arrives while the FIFO is full aborts the frame. It sets status bit 5 and `fifo_ovf`, and the block returns to idle. A pop from an empty FIFO sets `fifo_unf` and leaves the count at 0. `tx_done` flushes the FIFO and both flags.
- R4: With `crc_off` low, a frame fails its CRC check (status bit 3) unless CRC-16 over all received bits leaves the residue 0x1D0F. The CRC uses polynomial 0x1021 and preset 0xFFFF, and the transmitted CRC is the complemented value, sent MSB first. With `crc_off` high, the check is skipped.
- R5: With a non-zero expected length, the frame ends as soon as that many bits have been accepted, and later bits are ignored. A `frame_end` pulse before the length is reached sets status bit 2 (short stream). A zero length means the frame ends only on `frame_end`.
- R6: A frame with no overflow, no short stream and no CRC fault sets status bit 4 and clears the expected-length register (`exp_len`) to 0. A failed frame leaves `exp_len` unchanged.
- R7: With `early_mode` high, status bit 6 is set when the 16th bit of a frame is accepted. A length written after that point takes effect for the frame in progress.
- R8: `preamble_err` while listening or receiving sets status bit 1 and abandons the frame.
- R9: If no bit arrives within NORESP_CYCLES cycles after the guard ends, status bit 0 is set and the block returns to idle.
- R10: `tx_done` sets status bit 7. Status bits are sticky until `irq_clr`, which clears all bits that are not being set in the same cycle. `irq` is high when any status bit is set whose `irq_en` bit is also set.
- R11: After reset, the status is 0, the FIFO is empty with both flags low, `exp_len` is 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_done | input | 1 | Pulse: transmission ended, start a new receive window |
| guard_cycles | input | 8 | Guard interval in units of GUARD_UNIT cycles |
| bit_valid | input | 1 | Decoded bit strobe |
| bit_data | input | 1 | Decoded bit value |
| frame_end | input | 1 | Pulse: decoder saw the end of the reply |
| preamble_err | input | 1 | Pulse: decoder rejected the preamble |
| crc_off | input | 1 | Skip the CRC check |
| early_mode | input | 1 | Enable the 16-bit early interrupt |
| len_wr | input | 1 | Write strobe for the expected length |
| len_wdata | input | LEN_W (12) | Expected length in bits |
| exp_len | output | LEN_W (12) | Current expected length |
| rd_en | input | 1 | Pop the FIFO |
| rd_data | output | 8 | Oldest FIFO byte |
| fifo_count | output | CNT_W (5) | Bytes held in the FIFO |
| fifo_ovf | output | 1 | Sticky FIFO overflow flag |
| fifo_unf | output | 1 | Sticky FIFO underflow flag |
| irq_en | input | 8 | Interrupt enables, one per status bit |
| irq_clr | input | 1 | Clear the status register |
| irq_status | output | 8 | Sticky interrupt causes |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with GUARD_UNIT=2, NORESP_CYCLES=40 and the default 24-byte FIFO. These values keep every guard value from 0 to 3 cheap to sweep against payloads of one to four bytes plus CRC, with and without gaps between bits. They also let the no-response timeout expire and the FIFO overflow on its 25th byte within a few hundred cycles. At that size, the full-FIFO abort, the underflow on an empty pop, the partial-byte flush, the early-length rewrite, and each error cause can all be reached directly and checked against values the bench works out itself.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_GUARD  = 3'd1,
        ST_LISTEN = 3'd2,
        ST_RECV   = 3'd3,
        ST_FINISH = 3'd4
    } rxf_state_e;

    localparam int IRQ_NORESP = 0;
    localparam int IRQ_PRE    = 1;
    localparam int IRQ_SHORT  = 2;
    localparam int IRQ_CRC    = 3;
    localparam int IRQ_DONE   = 4;
    localparam int IRQ_FIFO   = 5;
    localparam int IRQ_EARLY  = 6;
    localparam int IRQ_TX     = 7;

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_POLY    = 16'h1021;
    localparam logic [15:0] CRC_RESIDUE = 16'h1D0F;

    function automatic logic [15:0] crc16_step(input logic [15:0] cur, input logic din);
        logic fb;
        fb = cur[15] ^ din;
        return {cur[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/rxf_countdown.sv
module rxf_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end
endmodule

// File: rtl/rxf_crc16.sv
module rxf_crc16
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= CRC_PRESET;
        end else if (init) begin
            crc <= CRC_PRESET;
        end else if (en) begin
            crc <= crc16_step(crc, din);
        end
    end
endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
    parameter int DEPTH = 24,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    pop_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          ovf_flag,
    output logic          unf_flag
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign full     = (count == CW'(DEPTH));
    assign do_pop   = pop && (count != '0);
    assign do_push  = push && (!full || do_pop);
    assign pop_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else if (flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
            if (push && !do_push)  ovf_flag <= 1'b1;
            if (pop && count == '0) unf_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import rxf_pkg::*;
#(
    parameter int DEPTH         = 24,
    parameter int LEN_W         = 12,
    parameter int GUARD_UNIT    = 8,
    parameter int NORESP_CYCLES = 2000,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_done,
    input  logic [7:0]       guard_cycles,
    input  logic             bit_valid,
    input  logic             bit_data,
    input  logic             frame_end,
    input  logic             preamble_err,
    input  logic             crc_off,
    input  logic             early_mode,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_wdata,
    output logic [LEN_W-1:0] exp_len,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] fifo_count,
    output logic             fifo_ovf,
    output logic             fifo_unf,
    input  logic [7:0]       irq_en,
    input  logic             irq_clr,
    output logic [7:0]       irq_status,
    output logic             irq
);
    localparam int GT_W = $clog2(255 * GUARD_UNIT + 1);
    localparam int NR_W = $clog2(NORESP_CYCLES + 1);

    rxf_state_e       state_q, state_d;
    logic [7:0]       byte_sr_q;
    logic [2:0]       bits_in_q;
    logic [LEN_W-1:0] bit_cnt_q;
    logic [LEN_W-1:0] len_q;
    logic [GT_W-1:0]  guard_cnt;
    logic [NR_W-1:0]  nr_cnt;
    logic [15:0]      crc_val;
    logic [7:0]       stat_set;
    logic             fifo_full;

    logic       accept, end_hit, push, ovf_now, nr_load;
    logic [7:0] push_data, part_byte;
    logic       fin, fin_part, fin_ovf, fin_short, fin_crc_bad, fin_ok;

    // ---------------- bit intake and frame judgement ----------------
    assign accept    = bit_valid && !tx_done &&
                       (state_q == ST_LISTEN || state_q == ST_RECV);
    assign end_hit   = frame_end ||
                       (accept && len_q != '0 && (bit_cnt_q + LEN_W'(1)) == len_q);
    assign part_byte = byte_sr_q << (4'd8 - {1'b0, bits_in_q});

    assign fin         = (state_q == ST_FINISH);
    assign fin_part    = (bits_in_q != 3'd0);
    assign fin_ovf     = fin && fin_part && fifo_full && !rd_en;
    assign fin_short   = (len_q != '0) && (bit_cnt_q < len_q);
    assign fin_crc_bad = !crc_off && (crc_val != CRC_RESIDUE);
    assign fin_ok      = fin && !fin_ovf && !fin_short && !fin_crc_bad;

    assign push      = (accept && bits_in_q == 3'd7) || (fin && fin_part);
    assign push_data = fin ? part_byte : {byte_sr_q[6:0], bit_data};
    assign ovf_now   = push && fifo_full && !rd_en;

    // ---------------- sub-blocks ----------------
    rxf_countdown #(.W(GT_W)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_done),
        .load_val (GT_W'(guard_cycles) * GT_W'(GUARD_UNIT)),
        .dec      (state_q == ST_GUARD),
        .cnt      (guard_cnt)
    );

    assign nr_load = (state_d == ST_LISTEN) && (state_q != ST_LISTEN || tx_done);

    rxf_countdown #(.W(NR_W)) u_noresp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (nr_load),
        .load_val (NR_W'(NORESP_CYCLES)),
        .dec      (state_q == ST_LISTEN),
        .cnt      (nr_cnt)
    );

    rxf_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (tx_done),
        .en    (accept),
        .din   (bit_data),
        .crc   (crc_val)
    );

    rxf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_done),
        .push      (push),
        .push_data (push_data),
        .pop       (rd_en),
        .pop_data  (rd_data),
        .count     (fifo_count),
        .full      (fifo_full),
        .ovf_flag  (fifo_ovf),
        .unf_flag  (fifo_unf)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        if (tx_done) begin
            state_d = (guard_cycles == 8'd0) ? ST_LISTEN : ST_GUARD;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_GUARD:  if (guard_cnt <= GT_W'(1)) state_d = ST_LISTEN;
                ST_LISTEN: begin
                    if (preamble_err)            state_d = ST_IDLE;
                    else if (accept)             state_d = end_hit ? ST_FINISH : ST_RECV;
                    else if (nr_cnt <= NR_W'(1)) state_d = ST_IDLE;
                end
                ST_RECV: begin
                    if (preamble_err || ovf_now) state_d = ST_IDLE;
                    else if (end_hit)            state_d = ST_FINISH;
                end
                ST_FINISH: state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- status causes ----------------
    always_comb begin
        stat_set             = 8'h00;
        stat_set[IRQ_TX]     = tx_done;
        stat_set[IRQ_EARLY]  = accept && early_mode && bit_cnt_q == LEN_W'(15);
        stat_set[IRQ_FIFO]   = ovf_now;
        stat_set[IRQ_DONE]   = fin_ok;
        stat_set[IRQ_CRC]    = fin && !fin_ovf && !fin_short && fin_crc_bad;
        stat_set[IRQ_SHORT]  = fin && !fin_ovf && fin_short;
        stat_set[IRQ_PRE]    = !tx_done && preamble_err &&
                               (state_q == ST_LISTEN || state_q == ST_RECV);
        stat_set[IRQ_NORESP] = !tx_done && !preamble_err && !accept &&
                               state_q == ST_LISTEN && nr_cnt <= NR_W'(1);
    end

    // ---------------- output / datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_sr_q  <= 8'h00;
            bits_in_q  <= 3'd0;
            bit_cnt_q  <= '0;
            len_q      <= '0;
            irq_status <= 8'h00;
        end else begin
            if (tx_done) begin
                byte_sr_q <= 8'h00;
                bits_in_q <= 3'd0;
                bit_cnt_q <= '0;
            end else if (accept) begin
                byte_sr_q <= {byte_sr_q[6:0], bit_data};
                bits_in_q <= bits_in_q + 3'd1;
                bit_cnt_q <= bit_cnt_q + LEN_W'(1);
            end
            if (fin_ok)      len_q <= '0;
            else if (len_wr) len_q <= len_wdata;
            irq_status <= (irq_clr ? 8'h00 : irq_status) | stat_set;
        end
    end

    assign exp_len = len_q;
    assign irq     = |(irq_status & irq_en);

endmodule

// File: rtl/rx_framer_checker.sv
module rx_framer_checker
    import rxf_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int LEN_W = 12,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input rxf_state_e       state_q,
    input logic [CNT_W-1:0] fifo_count,
    input logic             rd_en,
    input logic             tx_done,
    input logic             fifo_ovf,
    input logic [7:0]       irq_status,
    input logic [LEN_W-1:0] len_q,
    input logic             early_mode,
    input logic [LEN_W-1:0] bit_cnt_q
);
    AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GUARD && !rd_en && !tx_done) |=> $stable(fifo_count)); // R1

    AST_LISTEN_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LISTEN) |-> (bit_cnt_q == '0)); // R1

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH)); // R2

    AST_OVF_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_ovf) |-> irq_status[IRQ_FIFO]); // R3

    AST_DONE_CLEARS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[IRQ_DONE]) |-> (len_q == '0)); // R6

    AST_EARLY_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[IRQ_EARLY]) |-> $past(early_mode)); // R7
endmodule

bind rx_framer rx_framer_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .fifo_count (fifo_count),
    .rd_en      (rd_en),
    .tx_done    (tx_done),
    .fifo_ovf   (fifo_ovf),
    .irq_status (irq_status),
    .len_q      (len_q),
    .early_mode (early_mode),
    .bit_cnt_q  (bit_cnt_q)
);

// File: tb/rx_framer_test.sv
module rx_framer_test;
    localparam int CLK_PERIOD    = 10;
    localparam int DEPTH         = 24;
    localparam int LEN_W         = 12;
    localparam int GUARD_UNIT    = 2;
    localparam int NORESP_CYCLES = 40;
    localparam int CNT_W         = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tx_done = 1'b0;
    logic [7:0]       guard_cycles = 8'd0;
    logic             bit_valid = 1'b0;
    logic             bit_data = 1'b0;
    logic             frame_end = 1'b0;
    logic             preamble_err = 1'b0;
    logic             crc_off = 1'b0;
    logic             early_mode = 1'b0;
    logic             len_wr = 1'b0;
    logic [LEN_W-1:0] len_wdata = '0;
    logic [LEN_W-1:0] exp_len;
    logic             rd_en = 1'b0;
    logic [7:0]       rd_data;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_ovf;
    logic             fifo_unf;
    logic [7:0]       irq_en = 8'hFF;
    logic             irq_clr = 1'b0;
    logic [7:0]       irq_status;
    logic             irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] fbuf [32];

    rx_framer #(
        .DEPTH(DEPTH), .LEN_W(LEN_W),
        .GUARD_UNIT(GUARD_UNIT), .NORESP_CYCLES(NORESP_CYCLES)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .guard_cycles(guard_cycles),
        .bit_valid(bit_valid), .bit_data(bit_data), .frame_end(frame_end),
        .preamble_err(preamble_err), .crc_off(crc_off), .early_mode(early_mode),
        .len_wr(len_wr), .len_wdata(len_wdata), .exp_len(exp_len),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_count(fifo_count),
        .fifo_ovf(fifo_ovf), .fifo_unf(fifo_unf), .irq_en(irq_en),
        .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: actual running expected finished");
        report();
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clr_pulses();
        tx_done = 1'b0; bit_valid = 1'b0; frame_end = 1'b0; preamble_err = 1'b0;
        len_wr = 1'b0; rd_en = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); clr_pulses(); end
    endtask

    task automatic drive_bit(input logic b);
        @(negedge clk); clr_pulses(); bit_valid = 1'b1; bit_data = b;
    endtask

    task automatic pulse_tx(input logic [7:0] g);
        @(negedge clk); clr_pulses(); guard_cycles = g; tx_done = 1'b1;
    endtask

    task automatic pulse_end();
        @(negedge clk); clr_pulses(); frame_end = 1'b1;
    endtask

    task automatic write_len(input int v);
        @(negedge clk); clr_pulses(); len_wr = 1'b1; len_wdata = LEN_W'(v);
    endtask

    task automatic clear_irq();
        @(negedge clk); clr_pulses(); irq_clr = 1'b1;
    endtask

    task automatic pop_byte(output logic [7:0] d);
        @(negedge clk); clr_pulses(); d = rd_data; rd_en = 1'b1;
    endtask

    function automatic logic [15:0] calc_crc(input int n);
        logic [15:0] c;
        logic fb;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int k = 7; k >= 0; k--) begin
                fb = c[15] ^ fbuf[i][k];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return ~c;
    endfunction

    task automatic build_frame(input int n, input int seed);
        logic [15:0] c;
        for (int i = 0; i < n; i++) fbuf[i] = 8'((seed * 37 + i * 91 + 5) & 255);
        c = calc_crc(n);
        fbuf[n]     = c[15:8];
        fbuf[n + 1] = c[7:0];
    endtask

    task automatic send_bytes(input int first, input int nb, input bit gaps);
        for (int i = first; i < first + nb; i++) begin
            for (int k = 7; k >= 0; k--) begin
                drive_bit(fbuf[i][k]);
                if (gaps) idle(1);
            end
        end
    endtask

    task automatic read_compare(input int nb, input string req);
        logic [7:0] d;
        for (int i = 0; i < nb; i++) begin
            pop_byte(d);
            check(req, "fifo byte", 32'(d), 32'(fbuf[i]));
        end
    endtask

    initial begin
        logic [7:0] d;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(1);

        // R11: reset state
        check("R11", "irq_status", 32'(irq_status), 32'h00);
        check("R11", "fifo_count", 32'(fifo_count), 32'd0);
        check("R11", "exp_len", 32'(exp_len), 32'd0);
        check("R11", "irq", 32'(irq), 32'd0);
        check("R11", "fifo flags", 32'({fifo_ovf, fifo_unf}), 32'd0);

        // R1 R2 R4 R6: sweep guard values and payload sizes
        for (int g = 0; g < 4; g++) begin
            for (int n = 1; n <= 4; n++) begin
                clear_irq();
                write_len((n + 2) * 8);
                idle(1);
                check("R6", "exp_len written", 32'(exp_len), 32'((n + 2) * 8));
                build_frame(n, g * 4 + n);
                pulse_tx(8'(g));
                for (int j = 0; j < g * GUARD_UNIT; j++) drive_bit(1'b1);
                send_bytes(0, n + 2, bit'(n % 2));
                idle(3);
                check("R4", "status after good frame", 32'(irq_status), 32'h90);
                check("R6", "exp_len cleared", 32'(exp_len), 32'd0);
                check("R2", "fifo_count", 32'(fifo_count), 32'(n + 2));
                read_compare(n + 2, "R1");
            end
        end

        // R10: interrupt enables and clear
        check("R10", "irq all enabled", 32'(irq), 32'd1);
        irq_en = 8'h00; idle(1);
        check("R10", "irq all masked", 32'(irq), 32'd0);
        irq_en = 8'h10; idle(1);
        check("R10", "irq done only", 32'(irq), 32'd1);
        irq_en = 8'h0F; idle(1);
        check("R10", "irq error causes only", 32'(irq), 32'd0);
        irq_en = 8'hFF;
        clear_irq(); idle(1);
        check("R10", "status cleared", 32'(irq_status), 32'h00);

        // R2: partial trailing bits, CRC skipped
        crc_off = 1'b1;
        write_len(0);
        fbuf[0] = 8'hA5; fbuf[1] = 8'hB0;
        pulse_tx(8'd0);
        send_bytes(0, 1, 1'b0);
        drive_bit(1'b1); drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b1);
        pulse_end();
        idle(3);
        check("R2", "status partial frame", 32'(irq_status), 32'h90);
        check("R2", "fifo_count partial", 32'(fifo_count), 32'd2);
        read_compare(2, "R2");

        // R5: auto end at length, extra bits ignored
        clear_irq();
        write_len(16);
        fbuf[0] = 8'h3C; fbuf[1] = 8'hC3; fbuf[2] = 8'hFF;
        pulse_tx(8'd0);
        send_bytes(0, 3, 1'b0);
        idle(3);
        check("R5", "status length reached", 32'(irq_status), 32'h90);
        check("R5", "extra byte ignored", 32'(fifo_count), 32'd2);
        read_compare(2, "R5");
        crc_off = 1'b0;

        // R4: corrupted CRC
        clear_irq();
        write_len(40);
        build_frame(3, 77);
        fbuf[1] = fbuf[1] ^ 8'h01;
        pulse_tx(8'd1);
        idle(GUARD_UNIT);
        send_bytes(0, 5, 1'b0);
        idle(3);
        check("R4", "status crc error", 32'(irq_status), 32'h88);
        check("R6", "exp_len kept on failure", 32'(exp_len), 32'd40);
        check("R2", "fifo_count crc frame", 32'(fifo_count), 32'd5);

        // R4: same frame with the check disabled
        crc_off = 1'b1;
        clear_irq();
        pulse_tx(8'd0);
        send_bytes(0, 5, 1'b0);
        idle(3);
        check("R4", "status crc skipped", 32'(irq_status), 32'h90);
        check("R6", "exp_len cleared crc skipped", 32'(exp_len), 32'd0);
        crc_off = 1'b0;

        // R5: short stream
        clear_irq();
        write_len(64);
        build_frame(3, 9);
        pulse_tx(8'd0);
        send_bytes(0, 3, 1'b0);
        pulse_end();
        idle(3);
        check("R5", "status short stream", 32'(irq_status), 32'h84);
        check("R6", "exp_len kept short", 32'(exp_len), 32'd64);

        // R7: early interrupt and mid-frame length
        clear_irq();
        early_mode = 1'b1;
        write_len(0);
        build_frame(4, 21);
        pulse_tx(8'd0);
        send_bytes(0, 1, 1'b0);
        idle(1);
        check("R7", "no early irq after 8 bits", 32'(irq_status[6]), 32'd0);
        send_bytes(1, 1, 1'b0);
        idle(1);
        check("R7", "early irq after 16 bits", 32'(irq_status[6]), 32'd1);
        write_len(48);
        send_bytes(2, 4, 1'b0);
        idle(3);
        check("R7", "status early frame", 32'(irq_status), 32'hD0);
        check("R7", "exp_len cleared early", 32'(exp_len), 32'd0);
        check("R7", "fifo_count early", 32'(fifo_count), 32'd6);
        read_compare(6, "R7");
        early_mode = 1'b0;

        // R3: overflow aborts, then underflow
        clear_irq();
        for (int i = 0; i < 25; i++) fbuf[i] = 8'(i * 3 + 1);
        pulse_tx(8'd0);
        send_bytes(0, 25, 1'b0);
        idle(2);
        check("R3", "status overflow", 32'(irq_status), 32'hA0);
        check("R3", "fifo_ovf", 32'(fifo_ovf), 32'd1);
        check("R3", "fifo full count", 32'(fifo_count), 32'(DEPTH));
        send_bytes(0, 1, 1'b0);
        idle(2);
        check("R3", "bits after abort ignored", 32'(fifo_count), 32'(DEPTH));
        read_compare(DEPTH, "R3");
        check("R3", "no underflow yet", 32'(fifo_unf), 32'd0);
        pop_byte(d);
        idle(1);
        check("R3", "fifo_unf", 32'(fifo_unf), 32'd1);
        check("R3", "count after empty pop", 32'(fifo_count), 32'd0);

        // R8: preamble fault while listening
        clear_irq();
        pulse_tx(8'd0);
        idle(2);
        @(negedge clk); clr_pulses(); preamble_err = 1'b1;
        idle(1);
        check("R8", "status preamble", 32'(irq_status), 32'h82);
        send_bytes(0, 1, 1'b0);
        idle(2);
        check("R8", "bits after preamble ignored", 32'(fifo_count), 32'd0);

        // R9: no response
        clear_irq();
        pulse_tx(8'd2);
        idle(2 * GUARD_UNIT + 20);
        check("R9", "no timeout yet", 32'(irq_status), 32'h80);
        idle(30);
        check("R9", "status no response", 32'(irq_status), 32'h81);
        send_bytes(0, 1, 1'b0);
        idle(2);
        check("R9", "bits after timeout ignored", 32'(fifo_count), 32'd0);

        report();
    end
endmodule